// File: doc/BRIEF.md
# Hysteresis Threshold Selection Unit

This block is the decision side of a voltage comparator, modelled with unsigned digital codes. It takes a code for the positive input and decides whether that input is ABOVE or BELOW a threshold. It also reports the threshold code it is using at that moment. The decision is kept in a register, and each cycle's threshold depends on the decision held from the cycle before. This feedback is what produces hysteresis.

In single-ended mode, two ladder taps are derived from a reference code. Each tap is selected by a 6-bit setting and scales the reference in 64 steps. The upper tap is used while the state is BELOW and the lower tap while the state is ABOVE. In differential mode, the threshold is the negative-input code itself. An optional enable widens it into a symmetric band of H codes, where H is a parameter, and the active edge of the band is the one facing away from the current state.

The enable input models the comparator running. While it is low, the decision is held at BELOW. When it rises, evaluation starts from that BELOW state.

Top module: `hyst_thresh_unit`

## Requirements
- R1: After reset and for as long as `en_i` is low, `above_o` is 0 (BELOW). In single-ended mode `thresh_o` then shows the upper tap.
- R2: A tap code equals floor(((T+1) × V) / 64). T is the 6-bit tap setting and V is `vref_i`. The product is formed at full width, so T = 63 yields exactly V.
- R3: In single-ended mode (`mode_diff_i` = 0) in state BELOW, `thresh_o` is the tap set by `th_up_i`. If `vin_p_i` is strictly greater than `thresh_o` at a rising edge, `above_o` is 1 after that edge.
- R4: In single-ended mode in state ABOVE, `thresh_o` is the tap set by `th_dn_i`. The state returns to BELOW only when `vin_p_i` is strictly less than that lower tap. Values between the two taps hold the state.
- R5: When `vin_p_i` equals `thresh_o`, the state does not change at the next edge, in any mode.
- R6: In differential mode with `hyst_en_i` = 0, `thresh_o` equals `vin_n_i`. Decisions use the strict rules of R3 and R4.
- R7: In differential mode with `hyst_en_i` = 1, `thresh_o` is `vin_n_i` + H/2 in state BELOW and `vin_n_i` − H/2 in state ABOVE. The upper edge saturates at the all-ones code and the lower edge saturates at 0.
- R8: In single-ended mode, `hyst_en_i` has no effect on `thresh_o` or on the decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Comparator running; low holds state BELOW |
| mode_diff_i | input | 1 | 0 single-ended, 1 differential |
| hyst_en_i | input | 1 | Differential hysteresis band enable |
| vin_p_i | input | CODE_W | Positive input code |
| vin_n_i | input | CODE_W | Negative input code (differential) |
| vref_i | input | CODE_W | Reference code for the ladder |
| th_up_i | input | 6 | Upper ladder tap setting |
| th_dn_i | input | 6 | Lower ladder tap setting |
| thresh_o | output | CODE_W | Active threshold code |
| above_o | output | 1 | Registered decision, 1 = ABOVE |

## Verification
The bench builds the block with CODE_W = 8 and HBAND = 6. With these values the full code range, 0 to 255, is easy to reach. The top ladder tap can be driven to exactly the reference, and the lowest tap on a zero reference gives 0. A half band of only 3 codes puts both saturation corners one or two steps from the range ends. Equality ties, the hold zone between the two taps, and the hysteresis enable in single-ended mode are each driven at exact code values.

// File: rtl/hts_pkg.sv
package hts_pkg;

    // Decision held between clock edges.
    typedef enum logic {
        ST_BELOW = 1'b0,
        ST_ABOVE = 1'b1
    } hts_state_e;

    // Number of bits in a ladder tap setting (64 steps).
    localparam int unsigned LADDER_BITS = 6;

    // Registered state of the unit.
    typedef struct packed {
        hts_state_e st;
    } hts_regs_t;

endpackage

// File: rtl/hts_ladder.sv
module hts_ladder #(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned TAP_W  = 6
) (
    input  logic [CODE_W-1:0] vref_i,
    input  logic [TAP_W-1:0]  tap_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int unsigned PROD_W = CODE_W + TAP_W + 1;

    logic [TAP_W:0]    step;
    logic [PROD_W-1:0] prod;

    // Tap setting T selects (T+1) of 2**TAP_W steps of the reference.
    assign step   = {1'b0, tap_i} + 1'b1;
    assign prod   = PROD_W'(step) * PROD_W'(vref_i);
    assign code_o = CODE_W'(prod >> TAP_W);

endmodule

// File: rtl/hts_band.sv
module hts_band #(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned HBAND  = 16
) (
    input  logic [CODE_W-1:0] center_i,
    output logic [CODE_W-1:0] hi_o,
    output logic [CODE_W-1:0] lo_o
);
    localparam logic [CODE_W:0]   HALF_W   = (CODE_W+1)'(HBAND / 2);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CODE_W:0] sum;

    assign sum = {1'b0, center_i} + HALF_W;

    always_comb begin
        // Upper edge clamps at the top code.
        if (sum[CODE_W]) begin
            hi_o = CODE_MAX;
        end else begin
            hi_o = sum[CODE_W-1:0];
        end
        // Lower edge clamps at zero.
        if ({1'b0, center_i} < HALF_W) begin
            lo_o = '0;
        end else begin
            lo_o = CODE_W'({1'b0, center_i} - HALF_W);
        end
    end

endmodule

// File: rtl/hyst_thresh_unit.sv
module hyst_thresh_unit
    import hts_pkg::*;
#(
    parameter int unsigned CODE_W = 10,
    parameter int unsigned HBAND  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              mode_diff_i,
    input  logic              hyst_en_i,
    input  logic [CODE_W-1:0] vin_p_i,
    input  logic [CODE_W-1:0] vin_n_i,
    input  logic [CODE_W-1:0] vref_i,
    input  logic [5:0]        th_up_i,
    input  logic [5:0]        th_dn_i,
    output logic [CODE_W-1:0] thresh_o,
    output logic              above_o
);
    localparam int unsigned NUM_TAPS = 2;
    localparam int unsigned TAP_DN   = 0;
    localparam int unsigned TAP_UP   = 1;

    hts_regs_t regs_d, regs_q;

    logic [LADDER_BITS-1:0] tap_sel  [NUM_TAPS];
    logic [CODE_W-1:0]      tap_code [NUM_TAPS];
    logic [CODE_W-1:0]      band_hi, band_lo;
    logic [CODE_W-1:0]      thr_sel;

    assign tap_sel[TAP_DN] = th_dn_i;
    assign tap_sel[TAP_UP] = th_up_i;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        hts_ladder #(
            .CODE_W (CODE_W),
            .TAP_W  (LADDER_BITS)
        ) u_ladder (
            .vref_i (vref_i),
            .tap_i  (tap_sel[g]),
            .code_o (tap_code[g])
        );
    end

    hts_band #(
        .CODE_W (CODE_W),
        .HBAND  (HBAND)
    ) u_band (
        .center_i (vin_n_i),
        .hi_o     (band_hi),
        .lo_o     (band_lo)
    );

    // Threshold facing away from the held decision, then next decision.
    always_comb begin
        if (mode_diff_i) begin
            if (!hyst_en_i) begin
                thr_sel = vin_n_i;
            end else if (regs_q.st == ST_ABOVE) begin
                thr_sel = band_lo;
            end else begin
                thr_sel = band_hi;
            end
        end else if (regs_q.st == ST_ABOVE) begin
            thr_sel = tap_code[TAP_DN];
        end else begin
            thr_sel = tap_code[TAP_UP];
        end

        regs_d = regs_q;
        if (!en_i) begin
            regs_d.st = ST_BELOW;
        end else if (regs_q.st == ST_BELOW && vin_p_i > thr_sel) begin
            regs_d.st = ST_ABOVE;
        end else if (regs_q.st == ST_ABOVE && vin_p_i < thr_sel) begin
            regs_d.st = ST_BELOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_BELOW};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign thresh_o = thr_sel;
    assign above_o  = (regs_q.st == ST_ABOVE);

endmodule

// File: rtl/hts_checker.sv
module hts_checker #(
    parameter int unsigned CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              mode_diff_i,
    input logic              hyst_en_i,
    input logic [CODE_W-1:0] vin_p_i,
    input logic [CODE_W-1:0] vin_n_i,
    input logic [CODE_W-1:0] vref_i,
    input logic [CODE_W-1:0] thresh_o,
    input logic              above_o
);

    // R1: idle forces BELOW on the next edge
    a_r1_idle_below: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !above_o);

    // R2: a ladder tap never exceeds the reference
    a_r2_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_diff_i |-> thresh_o <= vref_i);

    // R3: crossing upward sets ABOVE
    a_r3_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !above_o && vin_p_i > thresh_o) |=> above_o);

    // R4: crossing downward clears ABOVE
    a_r4_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && above_o && vin_p_i < thresh_o) |=> !above_o);

    // R5: a tie holds the decision
    a_r5_tie_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && vin_p_i == thresh_o) |=> $stable(above_o));

    // R7: band edges sit on the correct side of the centre
    a_r7_band_side_above: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_diff_i && hyst_en_i && above_o) |-> thresh_o <= vin_n_i);
    a_r7_band_side_below: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_diff_i && hyst_en_i && !above_o) |-> thresh_o >= vin_n_i);

endmodule

bind hyst_thresh_unit hts_checker #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/test_hyst_thresh_unit.sv
module test_hyst_thresh_unit;
    localparam int CW   = 8;
    localparam int HB   = 6;
    localparam int HALF = HB / 2;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, diff = 1'b0, hyst = 1'b0;
    logic [CW-1:0] vp = '0, vn = '0, vref = '0;
    logic [5:0]    up = '0, dn = '0;
    logic [CW-1:0] thr;
    logic          above;

    int applied = 0;
    int miscompares = 0;
    int ms = 0;
    bit done = 1'b0;

    typedef struct {
        int    above;
        int    thr;
        string tag;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    hyst_thresh_unit #(.CODE_W(CW), .HBAND(HB)) i_hyst_thresh_unit (
        .clk(clk), .rst_n(rst_n), .en_i(en), .mode_diff_i(diff),
        .hyst_en_i(hyst), .vin_p_i(vp), .vin_n_i(vn), .vref_i(vref),
        .th_up_i(up), .th_dn_i(dn), .thresh_o(thr), .above_o(above)
    );

    function automatic int m_thr(int st, int d, int h, int n, int r, int u, int w);
        if (d != 0) begin
            if (h == 0) return n;
            if (st != 0) return (n >= HALF) ? n - HALF : 0;
            return (n + HALF > CMAX) ? CMAX : n + HALF;
        end
        if (st != 0) return ((w + 1) * r) / 64;
        return ((u + 1) * r) / 64;
    endfunction

    task automatic apply(input bit e, input bit d, input bit h, input int p,
                         input int n, input int r, input int u, input int w,
                         input string tag);
        int t, nx;
        @(negedge clk);
        en = e; diff = d; hyst = h;
        vp = CW'(p); vn = CW'(n); vref = CW'(r); up = 6'(u); dn = 6'(w);
        t = m_thr(ms, d, h, n, r, u, w);
        if (!e)                   nx = 0;
        else if (ms == 0 && p > t) nx = 1;
        else if (ms == 1 && p < t) nx = 0;
        else                      nx = ms;
        ms = nx;
        q.push_back('{above: nx, thr: m_thr(nx, d, h, n, r, u, w), tag: tag});
    endtask

    // Monitor: compare one expected item per edge after it settles.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                applied++;
                if (int'(above) != it.above || int'(thr) != it.thr) begin
                    miscompares++;
                    $display("FAIL %s: actual above=%0d thr=%0d expected above=%0d thr=%0d",
                             it.tag, above, thr, it.above, it.thr);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle, upper tap shown, strong input ignored
        apply(0, 0, 0, 255, 0, 200, 40, 20, "R1 idle");
        apply(0, 0, 0, 255, 0, 200, 40, 20, "R1 idle hold");
        // R2: ladder corners while idle
        apply(0, 0, 0, 0, 0, 255, 63, 0, "R2 top tap");
        apply(0, 0, 0, 0, 0, 255, 0, 0, "R2 bottom tap");
        apply(0, 0, 0, 0, 0, 0, 63, 0, "R2 zero ref");
        apply(0, 0, 0, 0, 0, 131, 17, 5, "R2 rounding");
        // R3/R4: single-ended hysteresis (up=128, dn=65)
        apply(1, 0, 0, 100, 0, 200, 40, 20, "R3 below upper");
        apply(1, 0, 0, 129, 0, 200, 40, 20, "R3 cross up");
        apply(1, 0, 0, 100, 0, 200, 40, 20, "R4 hold zone");
        apply(1, 0, 0, 64, 0, 200, 40, 20, "R4 cross down");
        // R5: ties in both states
        apply(1, 0, 0, 128, 0, 200, 40, 20, "R5 tie upper");
        apply(1, 0, 0, 200, 0, 200, 40, 20, "R5 go above");
        apply(1, 0, 0, 65, 0, 200, 40, 20, "R5 tie lower");
        // R8: hysteresis enable ignored in single-ended mode
        apply(1, 0, 1, 65, 0, 200, 40, 20, "R8 se hyst tie");
        apply(1, 0, 1, 64, 0, 200, 40, 20, "R8 se hyst down");
        apply(1, 0, 1, 128, 0, 200, 40, 20, "R8 se hyst tie up");
        // R6: differential without band
        apply(1, 1, 0, 100, 100, 0, 0, 0, "R6 tie");
        apply(1, 1, 0, 101, 100, 0, 0, 0, "R6 above");
        apply(1, 1, 0, 100, 100, 0, 0, 0, "R6 tie above");
        apply(1, 1, 0, 99, 100, 0, 0, 0, "R6 below");
        // R7: differential band
        apply(1, 1, 1, 103, 100, 0, 0, 0, "R7 edge tie");
        apply(1, 1, 1, 104, 100, 0, 0, 0, "R7 above");
        apply(1, 1, 1, 97, 100, 0, 0, 0, "R7 lower tie");
        apply(1, 1, 1, 96, 100, 0, 0, 0, "R7 below");
        apply(1, 1, 1, 255, 254, 0, 0, 0, "R7 top saturate");
        apply(1, 1, 1, 6, 2, 0, 0, 0, "R7 above near zero");
        apply(1, 1, 1, 0, 2, 0, 0, 0, "R7 zero saturate");
        // R1: dropping enable returns to BELOW
        apply(0, 1, 1, 255, 2, 0, 0, 0, "R1 stop");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule